// File: doc/BRIEF.md
# Sequenced Multichannel Converter Serial Port Controller

This block is the digital control side of an eight-channel sampling converter. It sits behind a four-wire serial port made of an active-low select, a serial clock, a serial input and a serial output. The analog front end is replaced by a flat port that carries one 12-bit sample per channel. When select falls, the block picks a channel and latches that channel's sample. Over the next sixteen falling serial-clock edges it shifts out a result word that carries the channel number. On the same edges it shifts in a command word that configures the following conversion.

The command word holds a write-enable flag, two sequencing flags, a channel address, a power-mode field, a range flag and an output-coding flag. A 16-bit mask word, loaded in a frame of its own, lets the block step through a chosen set of channels without further addressing. One command mode steps through channels 0 up to the address instead. The power-mode and range fields have no effect on the conversion path. They drive status outputs only.

All port signals are sampled on the system clock `clk`. Edges of select and serial clock are detected one system clock after they arrive.

Top module: `adcif_core`

## Requirements
- R1: After reset, `sdo_en` is 0, `pwr_state_o` is 4'b0001, `wide_range_o` is 0, and the first conversion uses channel 0 with straight binary coding.
- R2: `sdo_en` is 1 only while `cs_n` is low. It drops one clock after `cs_n` rises. `sdo` is 0 whenever `sdo_en` is 0.
- R3: The result frame is a 0 bit, then the 3-bit channel number MSB first, then the 12-bit result MSB first. The first bit appears after select falls, and each later bit appears after a falling serial-clock edge.
- R4: The sample is taken when select falls. Changes on `sample_i` later in the frame do not change the result.
- R5: `sdi` is captured on falling serial-clock edges. The first bit captured is bit 15 of the command word.
- R6: Command word layout: bit 15 write-enable, bit 14 seq flag, bit 13 mask flag, bits 12:10 address, bits 9:8 power mode, bit 7 range, bit 6 coding (1 = twos complement). Bits 5:0 are unused. A write takes effect at the 16th falling edge and applies to the next conversion, not to the current one.
- R7: A frame whose bit 15 is 0, and which is not a mask frame, leaves the command settings unchanged.
- R8: A frame in which select rises before the 16th falling edge changes no settings and does not move the channel sequence.
- R9: When seq=0 and mask=0, the next conversion uses the written address.
- R10: When seq=0 and mask=1, the next conversion uses the written address, and the frame after it loads its bits 7:0 as a channel mask. From then on, conversions start at the lowest set mask bit and step upward through the set bits, wrapping around. A mask of zero acts as 8'h01.
- R11: While sequencing, each full frame advances to the next set mask bit. This holds for frames with write-enable 0 and for writes with seq=1 and mask=0, which keep the sequence running.
- R12: When seq=1 and mask=1, the sequence covers channels 0 up to the written address, and it starts at 0.
- R13: In twos-complement coding, the result MSB is inverted. `wide_range_o` shows the range bit, and `pwr_state_o` is one-hot with bit n set for power mode n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; idles high |
| sdi | input | 1 | Serial command data |
| sample_i | input | 96 | Channel n sample in bits [12n+11:12n] |
| sdo | output | 1 | Serial result data |
| sdo_en | output | 1 | Output drive enable (0 = high impedance) |
| wide_range_o | output | 1 | Range bit status |
| pwr_state_o | output | 4 | One-hot power mode status |

## Verification
The block updates `sdo` and `sdo_en` at the first clock edge after the edge of `cs_n` or `sclk` that causes the change. The bench therefore drives inputs on falling clock edges and reads each serial bit two falling clock edges after the edge that produced it. Command and mask writes land on the clock after the 16th falling serial edge, so the status outputs are read after select has risen. The channel and coding chosen by a write are checked in the result word of the frame that follows it.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
    localparam int NCH     = 8;
    localparam int CH_W    = $clog2(NCH);
    localparam int DATA_W  = 12;
    localparam int FRAME_W = 1 + CH_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int PM_W    = 2;
    localparam int NPWR    = 1 << PM_W;

    // command word bit positions
    localparam int B_WR    = FRAME_W - 1;
    localparam int B_SEQ   = FRAME_W - 2;
    localparam int B_SHD   = FRAME_W - 3;
    localparam int B_ADDR  = FRAME_W - 4 - CH_W + 1;
    localparam int B_PM    = B_ADDR - PM_W;
    localparam int B_RNG   = B_PM - 1;
    localparam int B_TWOS  = B_RNG - 1;

    typedef struct packed {
        logic            seq;
        logic            shd;
        logic [CH_W-1:0] addr;
        logic [PM_W-1:0] pm;
        logic            rng;
        logic            twos;
    } ctrl_t;

    typedef struct packed {
        ctrl_t           ctrl;
        logic [NCH-1:0]  mask;
        logic [CH_W-1:0] nxt_ch;
        logic [CH_W-1:0] cur_ch;
        logic            seq_on;
        logic            shd_pend;
    } seq_state_t;

    typedef struct packed {
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
        logic [CNT_W-1:0]   cnt;
        logic               en;
    } frame_state_t;

    typedef struct packed {
        logic cs;
        logic sclk;
    } edge_state_t;
endpackage

// File: rtl/adcif_edge.sv
module adcif_edge
    import adcif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic cs_fall,
    output logic sclk_fall
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cs   = cs_n;
        st_d.sclk = sclk;
        cs_fall   = st_q.cs & ~cs_n;
        sclk_fall = st_q.sclk & ~sclk & ~cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cs: 1'b1, sclk: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/adcif_seq.sv
module adcif_seq
    import adcif_pkg::*;
(
    input  logic [NCH-1:0]  mask,
    input  logic [CH_W-1:0] cur,
    output logic [CH_W-1:0] nxt,
    output logic [CH_W-1:0] first
);
    logic found_n, found_f;
    logic [CH_W-1:0] idx;

    always_comb begin
        nxt     = cur;
        found_n = 1'b0;
        idx     = '0;
        for (int k = 1; k <= NCH; k++) begin
            idx = cur + CH_W'(k);
            if (!found_n && mask[idx]) begin
                nxt     = idx;
                found_n = 1'b1;
            end
        end
    end

    always_comb begin
        first   = '0;
        found_f = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (!found_f && mask[i]) begin
                first   = CH_W'(i);
                found_f = 1'b1;
            end
        end
    end
endmodule

// File: rtl/adcif_frame.sv
module adcif_frame
    import adcif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               cs_fall,
    input  logic               sclk_fall,
    input  logic               sdi,
    input  logic [FRAME_W-1:0] load_word,
    output logic               frame_done,
    output logic [FRAME_W-1:0] rx_word,
    output logic               sdo,
    output logic               sdo_en
);
    frame_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.en    = ~cs_n;
        rx_word    = {st_q.rx[FRAME_W-2:0], sdi};
        frame_done = sclk_fall && (st_q.cnt == CNT_W'(FRAME_W - 1));
        if (cs_fall) begin
            st_d.tx  = load_word;
            st_d.cnt = '0;
        end else if (sclk_fall && st_q.cnt < CNT_W'(FRAME_W)) begin
            st_d.tx  = {st_q.tx[FRAME_W-2:0], 1'b0};
            st_d.rx  = rx_word;
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo    = st_q.tx[FRAME_W-1] & st_q.en;
    assign sdo_en = st_q.en;

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(FRAME_W)); // R5

    AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> !sdo); // R3
endmodule

// File: rtl/adcif_core.sv
module adcif_core
    import adcif_pkg::*;
#(
    parameter int NUM_CH  = NCH,
    parameter int SMP_W   = DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     sclk,
    input  logic                     sdi,
    input  logic [NUM_CH*SMP_W-1:0]  sample_i,
    output logic                     sdo,
    output logic                     sdo_en,
    output logic                     wide_range_o,
    output logic [NPWR-1:0]          pwr_state_o
);
    localparam int ADDR_HI = B_ADDR + CH_W - 1;
    localparam int PM_HI   = B_PM + PM_W - 1;

    logic               cs_fall, sclk_fall, frame_done;
    logic [FRAME_W-1:0] rx_word, load_word;
    logic [CH_W-1:0]    adv_ch, adv_first, new_first, unused_nxt;
    logic [NCH-1:0]     new_mask;
    logic [SMP_W-1:0]   code;
    seq_state_t         st_d, st_q;
    ctrl_t              wr_ctrl;

    adcif_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .cs_fall   (cs_fall),
        .sclk_fall (sclk_fall)
    );

    adcif_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .cs_fall    (cs_fall),
        .sclk_fall  (sclk_fall),
        .sdi        (sdi),
        .load_word  (load_word),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .sdo        (sdo),
        .sdo_en     (sdo_en)
    );

    // stepping through the running mask
    adcif_seq u_adv (
        .mask  (st_q.mask),
        .cur   (st_q.cur_ch),
        .nxt   (adv_ch),
        .first (adv_first)
    );

    // start point of a freshly loaded mask
    adcif_seq u_new (
        .mask  (new_mask),
        .cur   ('0),
        .nxt   (unused_nxt),
        .first (new_first)
    );

    always_comb begin
        new_mask = (rx_word[NCH-1:0] == '0) ? NCH'(1) : rx_word[NCH-1:0];
        wr_ctrl  = '{seq:  rx_word[B_SEQ],
                     shd:  rx_word[B_SHD],
                     addr: rx_word[ADDR_HI:B_ADDR],
                     pm:   rx_word[PM_HI:B_PM],
                     rng:  rx_word[B_RNG],
                     twos: rx_word[B_TWOS]};
        code = sample_i[int'(st_q.nxt_ch)*SMP_W +: SMP_W];
        if (st_q.ctrl.twos) code[SMP_W-1] = ~code[SMP_W-1];
        load_word = {1'b0, st_q.nxt_ch, code};
    end

    always_comb begin
        st_d = st_q;
        if (cs_fall) st_d.cur_ch = st_q.nxt_ch;
        if (frame_done) begin
            if (st_q.shd_pend) begin
                st_d.mask     = new_mask;
                st_d.seq_on   = 1'b1;
                st_d.shd_pend = 1'b0;
                st_d.nxt_ch   = new_first;
            end else if (rx_word[B_WR]) begin
                st_d.ctrl = wr_ctrl;
                unique case ({wr_ctrl.seq, wr_ctrl.shd})
                    2'b00: begin
                        st_d.seq_on = 1'b0;
                        st_d.nxt_ch = wr_ctrl.addr;
                    end
                    2'b01: begin
                        st_d.seq_on   = 1'b0;
                        st_d.shd_pend = 1'b1;
                        st_d.nxt_ch   = wr_ctrl.addr;
                    end
                    2'b10: begin
                        st_d.nxt_ch = st_q.seq_on ? adv_ch : wr_ctrl.addr;
                    end
                    default: begin
                        for (int i = 0; i < NCH; i++)
                            st_d.mask[i] = (CH_W'(i) <= wr_ctrl.addr);
                        st_d.seq_on = 1'b1;
                        st_d.nxt_ch = '0;
                    end
                endcase
            end else if (st_q.seq_on) begin
                st_d.nxt_ch = adv_ch;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wide_range_o = st_q.ctrl.rng;
    assign pwr_state_o  = NPWR'(1) << st_q.ctrl.pm;

    AST_WR_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !rx_word[B_WR] && !st_q.shd_pend) |=> $stable(st_q.ctrl)); // R7

    AST_SEQ_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seq_on |-> st_q.mask[st_q.nxt_ch]); // R11

    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seq_on |-> (st_q.mask != '0)); // R10

    AST_HIZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (!sdo_en && !sdo)); // R2

    AST_FIRST_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask != '0) |-> st_q.mask[adv_first]); // R10
endmodule

// File: tb/sim_adcif_core.sv
module sim_adcif_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic [95:0] sample_i;
    logic        sdo, sdo_en, wide_range_o;
    logic [3:0]  pwr_state_o;
    int          checks = 0;
    int          fails = 0;

    always #4 clk = ~clk;

    adcif_core u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .sdi          (sdi),
        .sample_i     (sample_i),
        .sdo          (sdo),
        .sdo_en       (sdo_en),
        .wide_range_o (wide_range_o),
        .pwr_state_o  (pwr_state_o)
    );

    // {command word, expected channel, expected twos flag}
    localparam logic [19:0] VEC [0:16] = '{
        {16'h9700, 3'd0, 1'b0},  // R1 first conversion ch0, single write addr5 pm3
        {16'h8840, 3'd5, 1'b0},  // R6 twos written now, applies next
        {16'h0000, 3'd2, 1'b1},  // R9 addr2 twos
        {16'h0000, 3'd2, 1'b1},  // R7 write-enable low keeps settings
        {16'hE800, 3'd2, 1'b1},  // R12 run 0..2
        {16'h0000, 3'd0, 1'b0},
        {16'h0000, 3'd1, 1'b0},
        {16'h0000, 3'd2, 1'b0},
        {16'h0000, 3'd0, 1'b0},  // R12 wrap
        {16'hBC40, 3'd1, 1'b0},  // R10 mask mode addr7
        {16'h00A4, 3'd7, 1'b1},  // R10 mask frame, converts addr
        {16'h0000, 3'd2, 1'b1},  // R10 lowest set bit
        {16'hC100, 3'd5, 1'b1},  // R11 continue mode
        {16'h0000, 3'd7, 1'b0},
        {16'h0000, 3'd2, 1'b0},  // R11 wrap
        {16'h9000, 3'd5, 1'b0},
        {16'h0000, 3'd4, 1'b0}   // R9
    };

    function automatic logic [11:0] smp(input int ch);
        return 12'h800 + 12'(ch) * 12'h111;
    endfunction

    function automatic logic [15:0] exp_frame(input logic [2:0] ch, input logic twos);
        logic [11:0] c;
        c = smp(int'(ch));
        if (twos) c[11] = ~c[11];
        return {1'b0, ch, c};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_frame(input logic [15:0] din, input int nclk, input bit poke,
                            output logic [15:0] dout);
        dout = '0;
        @(negedge clk);
        cs_n = 1'b0;
        sdi  = din[15];
        repeat (2) @(negedge clk);
        dout[15] = sdo;
        if (poke) sample_i[3*12 +: 12] = 12'h123;
        for (int i = 0; i < nclk; i++) begin
            sdi = din[15-i];
            @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            if (i < 15) dout[14-i] = sdo;
            sclk = 1'b1;
            @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        for (int c = 0; c < 8; c++) sample_i[c*12 +: 12] = smp(c);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sdo_en", {15'd0, sdo_en}, 16'd0);
        chk("R1 pwr_state", {12'd0, pwr_state_o}, 16'h0001);
        chk("R1 range", {15'd0, wide_range_o}, 16'd0);

        for (int v = 0; v < 17; v++) begin
            do_frame(VEC[v][19:4], 16, 1'b0, d);
            chk($sformatf("R3 R5 vector %0d", v), d, exp_frame(VEC[v][3:1], VEC[v][0]));
        end

        // R2: drive enable only inside the frame
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 enable low-select", {15'd0, sdo_en}, 16'd1);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 enable after rise", {14'd0, sdo_en, sdo}, 16'd0);

        // R13: status outputs (single addr3, pm2, range 1)
        do_frame(16'h8E80, 16, 1'b0, d);
        chk("R13 frame", d, exp_frame(3'd4, 1'b0));
        chk("R13 pwr_state", {12'd0, pwr_state_o}, 16'h0004);
        chk("R13 range", {15'd0, wide_range_o}, 16'd1);

        // R8: short frame carrying a write must change nothing
        do_frame(16'h9C40, 8, 1'b0, d);
        chk("R8 pwr_state", {12'd0, pwr_state_o}, 16'h0004);
        do_frame(16'h0000, 16, 1'b0, d);
        chk("R8 channel/coding kept", d, exp_frame(3'd3, 1'b0));

        // R4: sample change after select falls is not seen; mask mode addr6
        do_frame(16'hB800, 16, 1'b1, d);
        chk("R4 held sample", d, {1'b0, 3'd3, 12'hB33});
        sample_i[3*12 +: 12] = smp(3);

        // R10: zero mask acts as channel 0 only
        do_frame(16'h0000, 16, 1'b0, d);
        chk("R10 mask frame converts addr", d, exp_frame(3'd6, 1'b0));
        do_frame(16'h0000, 16, 1'b0, d);
        chk("R10 zero mask first", d, exp_frame(3'd0, 1'b0));
        do_frame(16'h0000, 16, 1'b0, d);
        chk("R10 zero mask repeat", d, exp_frame(3'd0, 1'b0));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule